// File: doc/BRIEF.md
# Packet Forwarding Decision Controller

This controller makes one forwarding decision per packet. When forwarding is enabled and it is idle, it asks the ingress buffer for a packet and waits for a grant, which also names the receiving port. It then takes nine 32-bit header words, covering the Ethernet header and a 20-byte IPv4 header, and latches the fields that steer forwarding. While the words arrive it also accumulates the IPv4 header checksum. From these fields it picks an agent: ICMP handling, layer-3 routing, ARP handling, or layer-2 switching.

All agents sit behind one shared request/done handshake. The controller holds the request together with a path code and a lookup key. The agent answers after any latency with a success flag and a port map. If the ICMP, layer-3 or ARP agent fails or stays silent, the controller retries the packet as layer-2. If layer-2 switching misses, the packet is flooded to every port except the one it arrived on. The decision is reported as a single-cycle done pulse carrying a path code and a destination port map. Each port has its own writable router IP address.

Top module: `fwd_ctrl`

## Requirements
- R1: After reset, `pkt_req`, `ag_req` and `done` are low and every router IP register holds 0.0.0.0.
- R2: `pkt_req` rises only on the cycle after an idle cycle in which `fwd_disable` was low. It stays high until `pkt_gnt`. Raising `fwd_disable` after a grant does not stop that packet from completing, but no further request is made.
- R3: The nine header words are taken on cycles with `word_valid` high, with the first byte of the frame in bits 31:24 of word 0. The fields are: word 3 bits 31:16 EtherType; word 4 bits 31:16 total length; word 5 bits 15:8 TTL and bits 7:0 protocol; word 6 bits 31:16 checksum; source IP in word 6 bits 15:0 and word 7 bits 31:16; destination IP in word 7 bits 15:0 and word 8 bits 31:16; destination MAC in word 0 and word 1 bits 31:16. These fields appear on the `hdr_*` outputs when `done` is high.
- R4: EtherType 0x0800 takes the IPv4 path, and 0x0806 is sent to the ARP agent. Any other value goes straight to layer-2 switching.
- R5: A healthy IPv4 packet goes to the ICMP agent when its destination IP equals the router IP of the receiving port and its protocol is 1. Otherwise it goes to the layer-3 agent.
- R6: An IPv4 packet whose ones'-complement header sum does not fold to 0xFFFF, or whose TTL is 0 or 1, is handled by layer-2 switching.
- R7: When the ICMP, layer-3 or ARP agent answers with `ag_ok` low, the controller makes a layer-2 request for the same packet. The result then reports the L2 path.
- R8: When the layer-2 agent answers with `ag_ok` low, the port map is all ports except the receiving one.
- R9: An agent that does not answer within `AG_TMO` cycles (default 100) is treated as a failure. Every decision completes within 320 cycles of the grant.
- R10: `done` is high for exactly one cycle per granted packet. `res_path` encodes L2=0, L3=1, ICMP=2, ARP=3. `res_ports` carries the agent's port map on success.
- R11: A write with `ip_we` high stores `ip_wdata` as the router IP of port `ip_wsel`. Other ports are unaffected.
- R12: `ag_req` stays high with a steady `ag_path` until `ag_done`. `ag_key` is the destination MAC for the L2 path and {16'h0, destination IP} for every other path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fwd_disable | input | 1 | Stops new packet requests |
| ip_we | input | 1 | Router IP write strobe |
| ip_wsel | input | 2 | Port whose router IP is written |
| ip_wdata | input | 32 | Router IP value |
| pkt_req | output | 1 | Request to the ingress buffer |
| pkt_gnt | input | 1 | Grant from the ingress buffer |
| pkt_port | input | 2 | Receiving port, valid with grant |
| word_valid | input | 1 | Header word valid |
| word_data | input | 32 | Header word |
| ag_req | output | 1 | Agent request |
| ag_path | output | 2 | Agent selected (path code) |
| ag_key | output | 48 | Lookup key for the agent |
| ag_done | input | 1 | Agent answer strobe |
| ag_ok | input | 1 | Agent success, valid with ag_done |
| ag_ports | input | 4 | Agent port map, valid with ag_done |
| done | output | 1 | Decision pulse |
| res_path | output | 2 | Decided path code |
| res_ports | output | 4 | Destination port map |
| hdr_src_ip | output | 32 | Source IP |
| hdr_dst_ip | output | 32 | Destination IP |
| hdr_proto | output | 8 | IP protocol |
| hdr_ttl | output | 8 | TTL |
| hdr_len | output | 16 | IP total length |
| hdr_csum | output | 16 | Header checksum field |

## Verification
The hardest case to reach from the ports is the double failure. Here an agent stays silent until its timeout, the layer-2 agent also stays silent, and the flood result still has to arrive inside the 320-cycle budget. The bench reaches it by granting a packet and then answering no request at all, and it measures the cycles from grant to done. The fallback chain is also driven one stage at a time: a refused layer-3 or ICMP request is answered with a layer-2 miss, so that both retry steps and the ingress-port exclusion in the flood map are observed.

// File: rtl/fwd_ctrl.sv
module fwd_ctrl #(
  parameter int NPORTS = 4,
  parameter int AG_TMO = 100,
  localparam int PW = $clog2(NPORTS),
  localparam int TW = $clog2(AG_TMO + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fwd_disable,
  input  logic              ip_we,
  input  logic [PW-1:0]     ip_wsel,
  input  logic [31:0]       ip_wdata,
  output logic              pkt_req,
  input  logic              pkt_gnt,
  input  logic [PW-1:0]     pkt_port,
  input  logic              word_valid,
  input  logic [31:0]       word_data,
  output logic              ag_req,
  output logic [1:0]        ag_path,
  output logic [47:0]       ag_key,
  input  logic              ag_done,
  input  logic              ag_ok,
  input  logic [NPORTS-1:0] ag_ports,
  output logic              done,
  output logic [1:0]        res_path,
  output logic [NPORTS-1:0] res_ports,
  output logic [31:0]       hdr_src_ip,
  output logic [31:0]       hdr_dst_ip,
  output logic [7:0]        hdr_proto,
  output logic [7:0]        hdr_ttl,
  output logic [15:0]       hdr_len,
  output logic [15:0]       hdr_csum
);
  localparam logic [1:0] P_L2 = 2'd0, P_L3 = 2'd1, P_ICMP = 2'd2, P_ARP = 2'd3;

  typedef enum logic [2:0] {S_IDLE, S_REQ, S_PARSE, S_DEC, S_AGENT, S_L2} st_t;

  st_t               st;
  logic [3:0]        wcnt;
  logic [PW-1:0]     port_q;
  logic [47:0]       dmac;
  logic [15:0]       etype;
  logic [19:0]       acc;
  logic [TW-1:0]     tmo;
  logic [1:0]        path;
  logic [31:0]       rip [NPORTS];

  wire [19:0] hsum    = {4'h0, word_data[31:16]} + {4'h0, word_data[15:0]};
  wire [16:0] fold1   = {1'b0, acc[15:0]} + {13'h0, acc[19:16]};
  wire [15:0] fold2   = fold1[15:0] + {15'h0, fold1[16]};
  wire        l3_good = (fold2 == 16'hFFFF) && (hdr_ttl > 8'd1);
  wire        is_ip   = etype == 16'h0800;
  wire        is_arp  = etype == 16'h0806;
  wire        to_me   = (hdr_dst_ip == rip[port_q]) && (hdr_proto == 8'd1);
  wire        tmo_end = tmo == TW'(AG_TMO - 1);
  wire [NPORTS-1:0] flood = ~(NPORTS'(1) << port_q);

  assign pkt_req = st == S_REQ;
  assign ag_req  = (st == S_AGENT) || (st == S_L2);
  assign ag_path = path;
  assign ag_key  = (path == P_L2) ? dmac : {16'h0, hdr_dst_ip};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      wcnt <= '0;
      port_q <= '0;
      dmac <= '0;
      etype <= '0;
      acc <= '0;
      tmo <= '0;
      path <= P_L2;
      done <= 1'b0;
      res_path <= P_L2;
      res_ports <= '0;
      hdr_src_ip <= '0;
      hdr_dst_ip <= '0;
      hdr_proto <= '0;
      hdr_ttl <= '0;
      hdr_len <= '0;
      hdr_csum <= '0;
      for (int i = 0; i < NPORTS; i++) rip[i] <= '0;
    end else begin
      done <= 1'b0;
      if (ip_we) rip[ip_wsel] <= ip_wdata;
      case (st)
        S_IDLE: if (!fwd_disable) st <= S_REQ;
        S_REQ: if (pkt_gnt) begin
          st <= S_PARSE;
          port_q <= pkt_port;
          wcnt <= '0;
          acc <= '0;
        end
        S_PARSE: if (word_valid) begin
          wcnt <= wcnt + 4'd1;
          case (wcnt)
            4'd0: dmac[47:16] <= word_data;
            4'd1: dmac[15:0] <= word_data[31:16];
            4'd3: begin
              etype <= word_data[31:16];
              acc <= {4'h0, word_data[15:0]};
            end
            4'd4: begin
              hdr_len <= word_data[31:16];
              acc <= acc + hsum;
            end
            4'd5: begin
              hdr_ttl <= word_data[15:8];
              hdr_proto <= word_data[7:0];
              acc <= acc + hsum;
            end
            4'd6: begin
              hdr_csum <= word_data[31:16];
              hdr_src_ip[31:16] <= word_data[15:0];
              acc <= acc + hsum;
            end
            4'd7: begin
              hdr_src_ip[15:0] <= word_data[31:16];
              hdr_dst_ip[31:16] <= word_data[15:0];
              acc <= acc + hsum;
            end
            4'd8: begin
              hdr_dst_ip[15:0] <= word_data[31:16];
              acc <= acc + {4'h0, word_data[31:16]};
              st <= S_DEC;
            end
            default: ;
          endcase
        end
        S_DEC: begin
          tmo <= '0;
          if (is_ip && l3_good) begin
            path <= to_me ? P_ICMP : P_L3;
            st <= S_AGENT;
          end else if (is_arp) begin
            path <= P_ARP;
            st <= S_AGENT;
          end else begin
            path <= P_L2;
            st <= S_L2;
          end
        end
        S_AGENT: begin
          if (ag_done && ag_ok) begin
            done <= 1'b1;
            res_path <= path;
            res_ports <= ag_ports;
            st <= S_IDLE;
          end else if (ag_done || tmo_end) begin
            path <= P_L2;
            tmo <= '0;
            st <= S_L2;
          end else begin
            tmo <= tmo + TW'(1);
          end
        end
        S_L2: begin
          if (ag_done || tmo_end) begin
            done <= 1'b1;
            res_path <= P_L2;
            res_ports <= (ag_done && ag_ok) ? ag_ports : flood;
            st <= S_IDLE;
          end else begin
            tmo <= tmo + TW'(1);
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/fwd_ctrl_chk.sv
module fwd_ctrl_chk #(
  parameter int BUDGET = 320
) (
  input logic       clk,
  input logic       rst_n,
  input logic       fwd_disable,
  input logic       pkt_req,
  input logic       pkt_gnt,
  input logic       done,
  input logic [1:0] res_path,
  input logic [7:0] hdr_proto,
  input logic [7:0] hdr_ttl
);
  logic        busy;
  logic [15:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt <= '0;
    end else if (pkt_req && pkt_gnt) begin
      busy <= 1'b1;
      cnt <= '0;
    end else if (done) begin
      busy <= 1'b0;
    end else if (busy) begin
      cnt <= cnt + 16'd1;
    end
  end

  p_req_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_req && !pkt_gnt |=> pkt_req);
  p_req_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pkt_req) |-> !$past(fwd_disable));
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_done_granted_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy);
  p_icmp_proto_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done && res_path == 2'd2 |-> hdr_proto == 8'd1);
  p_ttl_live_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done && (res_path == 2'd1 || res_path == 2'd2) |-> hdr_ttl > 8'd1);
  p_budget_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> cnt < 16'(BUDGET));
endmodule

bind fwd_ctrl fwd_ctrl_chk u_fwd_ctrl_chk (
  .clk(clk), .rst_n(rst_n), .fwd_disable(fwd_disable), .pkt_req(pkt_req),
  .pkt_gnt(pkt_gnt), .done(done), .res_path(res_path),
  .hdr_proto(hdr_proto), .hdr_ttl(hdr_ttl)
);

// File: tb/test_fwd_ctrl.sv
`timescale 1ns/1ps
module test_fwd_ctrl;
  logic clk = 1'b0, rst_n = 1'b0, fwd_disable = 1'b1;
  logic ip_we = 1'b0;
  logic [1:0] ip_wsel = '0;
  logic [31:0] ip_wdata = '0;
  logic pkt_req, pkt_gnt = 1'b0;
  logic [1:0] pkt_port = '0;
  logic word_valid = 1'b0;
  logic [31:0] word_data = '0;
  logic ag_req;
  logic [1:0] ag_path;
  logic [47:0] ag_key;
  logic ag_done = 1'b0, ag_ok = 1'b0;
  logic [3:0] ag_ports = '0;
  logic done;
  logic [1:0] res_path;
  logic [3:0] res_ports;
  logic [31:0] hdr_src_ip, hdr_dst_ip;
  logic [7:0] hdr_proto, hdr_ttl;
  logic [15:0] hdr_len, hdr_csum;

  fwd_ctrl i_fwd_ctrl (
    .clk(clk), .rst_n(rst_n), .fwd_disable(fwd_disable),
    .ip_we(ip_we), .ip_wsel(ip_wsel), .ip_wdata(ip_wdata),
    .pkt_req(pkt_req), .pkt_gnt(pkt_gnt), .pkt_port(pkt_port),
    .word_valid(word_valid), .word_data(word_data),
    .ag_req(ag_req), .ag_path(ag_path), .ag_key(ag_key),
    .ag_done(ag_done), .ag_ok(ag_ok), .ag_ports(ag_ports),
    .done(done), .res_path(res_path), .res_ports(res_ports),
    .hdr_src_ip(hdr_src_ip), .hdr_dst_ip(hdr_dst_ip), .hdr_proto(hdr_proto),
    .hdr_ttl(hdr_ttl), .hdr_len(hdr_len), .hdr_csum(hdr_csum)
  );

  always #2.5 clk = ~clk;

  localparam logic [1:0] L2 = 2'd0, L3 = 2'd1, ICMP = 2'd2, ARP = 2'd3;

  int n_cmp = 0, n_bad = 0, cyc = 0, grant_cyc = 0;
  bit finished = 0;
  logic [31:0] pw [9];
  logic [15:0] last_cs;
  logic [47:0] cur_dmac;
  logic [31:0] cur_dip;
  logic [1:0] got_path;
  logic [3:0] got_ports;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic build(input logic [47:0] dm, input logic [15:0] et, input logic [7:0] ttl,
                       input logic [7:0] pr, input logic [31:0] sip, input logic [31:0] dip,
                       input bit good);
    logic [15:0] h [10];
    int s;
    h = '{16'h4500, 16'd60, 16'h1234, 16'h4000, {ttl, pr}, 16'h0000,
          sip[31:16], sip[15:0], dip[31:16], dip[15:0]};
    s = 0;
    for (int i = 0; i < 10; i++) s += int'(h[i]);
    while (s > 32'hFFFF) s = (s & 32'hFFFF) + (s >> 16);
    last_cs = ~s[15:0];
    if (!good) last_cs = last_cs ^ 16'h0001;
    cur_dmac = dm;
    cur_dip = dip;
    pw[0] = dm[47:16];
    pw[1] = {dm[15:0], 16'h0a0b};
    pw[2] = 32'h0c0d0e0f;
    pw[3] = {et, 16'h4500};
    pw[4] = {16'd60, 16'h1234};
    pw[5] = {16'h4000, ttl, pr};
    pw[6] = {last_cs, sip[31:16]};
    pw[7] = {sip[15:0], dip[31:16]};
    pw[8] = {dip[15:0], 16'h0000};
  endtask

  task automatic send(input logic [1:0] port);
    while (!pkt_req) @(negedge clk);
    pkt_gnt = 1'b1;
    pkt_port = port;
    grant_cyc = cyc;
    @(negedge clk);
    pkt_gnt = 1'b0;
    for (int i = 0; i < 9; i++) begin
      if (i == 4) begin
        word_valid = 1'b0;
        word_data = 32'hDEADBEEF;
        @(negedge clk);
      end
      word_valid = 1'b1;
      word_data = pw[i];
      @(negedge clk);
    end
    word_valid = 1'b0;
  endtask

  task automatic serve(input logic [1:0] p, input bit ok, input logic [3:0] ports,
                       input int lat, input string req);
    int n = 0;
    while (!(ag_req && ag_path == p) && n < 400) begin
      @(negedge clk);
      n++;
    end
    check(ag_req && ag_path == p, req, "agent request path", {ag_req, ag_path}, {1'b1, p});
    check(ag_key == ((p == L2) ? cur_dmac : {16'h0, cur_dip}), "R12", "agent key",
          ag_key, (p == L2) ? cur_dmac : {16'h0, cur_dip});
    repeat (lat) @(negedge clk);
    check(ag_req && ag_path == p, "R12", "request held during latency", {ag_req, ag_path}, {1'b1, p});
    ag_ok = ok;
    ag_ports = ports;
    ag_done = 1'b1;
    @(negedge clk);
    ag_done = 1'b0;
  endtask

  task automatic wait_done(input logic [1:0] ep, input logic [3:0] eports, input string req);
    int n = 0;
    while (!done && n < 400) begin
      @(negedge clk);
      n++;
    end
    got_path = res_path;
    got_ports = res_ports;
    check(done, req, "done seen", done, 1);
    check(res_path == ep, req, "path code", res_path, ep);
    check(res_ports == eports, req, "port map", res_ports, eports);
    @(negedge clk);
    check(!done, "R10", "done one cycle", done, 0);
  endtask

  task automatic wr_ip(input logic [1:0] sel, input logic [31:0] v);
    ip_we = 1'b1;
    ip_wsel = sel;
    ip_wdata = v;
    @(negedge clk);
    ip_we = 1'b0;
  endtask

  task automatic t_reset;
    check(!pkt_req && !ag_req && !done, "R1", "outputs after reset", {pkt_req, ag_req, done}, 0);
  endtask

  task automatic t_disable;
    bit seen = 0;
    repeat (10) begin
      @(negedge clk);
      if (pkt_req) seen = 1;
    end
    check(!seen, "R2", "no request while disabled", seen, 0);
    fwd_disable = 1'b0;
    @(negedge clk);
    check(pkt_req, "R2", "request after enable", pkt_req, 1);
  endtask

  task automatic t_rip_reset;
    build(48'h0000_1111_2222, 16'h0800, 8'd64, 8'd1, 32'h0a000009, 32'h0, 1);
    send(2'd3);
    serve(ICMP, 1, 4'b1000, 2, "R1");
    wait_done(ICMP, 4'b1000, "R1");
  endtask

  task automatic t_l3;
    build(48'h0200_0000_0001, 16'h0800, 8'd33, 8'd6, 32'hc0a80105, 32'h0a010203, 1);
    send(2'd0);
    serve(L3, 1, 4'b0100, 5, "R5");
    wait_done(L3, 4'b0100, "R10");
    check(hdr_src_ip == 32'hc0a80105, "R3", "source ip", hdr_src_ip, 32'hc0a80105);
    check(hdr_dst_ip == 32'h0a010203, "R3", "dest ip", hdr_dst_ip, 32'h0a010203);
    check(hdr_ttl == 8'd33 && hdr_proto == 8'd6, "R3", "ttl/proto", {hdr_ttl, hdr_proto}, {8'd33, 8'd6});
    check(hdr_len == 16'd60 && hdr_csum == last_cs, "R3", "len/csum", {hdr_len, hdr_csum}, {16'd60, last_cs});
  endtask

  task automatic t_icmp;
    wr_ip(2'd2, 32'h0a000002);
    wr_ip(2'd1, 32'h0a000001);
    build(48'h0200_0000_0002, 16'h0800, 8'd10, 8'd1, 32'h0a000063, 32'h0a000002, 1);
    send(2'd2);
    serve(ICMP, 1, 4'b0100, 0, "R5");
    wait_done(ICMP, 4'b0100, "R11");
    send(2'd1);
    serve(L3, 1, 4'b0001, 1, "R11");
    wait_done(L3, 4'b0001, "R5");
    build(48'h0200_0000_0002, 16'h0800, 8'd10, 8'd17, 32'h0a000063, 32'h0a000002, 1);
    send(2'd2);
    serve(L3, 1, 4'b0010, 1, "R5");
    wait_done(L3, 4'b0010, "R5");
  endtask

  task automatic t_ethertype;
    build(48'hffff_ffff_ffff, 16'h0806, 8'd0, 8'd0, 32'h0, 32'h0a000002, 0);
    send(2'd1);
    serve(ARP, 1, 4'b0010, 3, "R4");
    wait_done(ARP, 4'b0010, "R4");
    build(48'h0300_0000_0007, 16'h86dd, 8'd64, 8'd6, 32'h1, 32'h2, 1);
    send(2'd0);
    serve(L2, 1, 4'b0010, 2, "R4");
    wait_done(L2, 4'b0010, "R4");
  endtask

  task automatic t_l3_fail;
    build(48'h0200_0000_0003, 16'h0800, 8'd64, 8'd6, 32'h01020304, 32'h05060708, 0);
    send(2'd0);
    serve(L2, 1, 4'b1000, 1, "R6");
    wait_done(L2, 4'b1000, "R6");
    build(48'h0200_0000_0004, 16'h0800, 8'd1, 8'd6, 32'h01020304, 32'h05060708, 1);
    send(2'd0);
    serve(L2, 1, 4'b0100, 1, "R6");
    wait_done(L2, 4'b0100, "R6");
    build(48'h0200_0000_0004, 16'h0800, 8'd2, 8'd6, 32'h01020304, 32'h05060708, 1);
    send(2'd0);
    serve(L3, 1, 4'b0010, 1, "R6");
    wait_done(L3, 4'b0010, "R6");
  endtask

  task automatic t_fallback;
    build(48'h0200_0000_0005, 16'h0800, 8'd64, 8'd6, 32'h01020304, 32'h05060708, 1);
    send(2'd3);
    serve(L3, 0, 4'b0001, 4, "R7");
    serve(L2, 1, 4'b0110, 2, "R7");
    wait_done(L2, 4'b0110, "R7");
    build(48'h0200_0000_0006, 16'h0800, 8'd64, 8'd1, 32'h01020304, 32'h0a000002, 1);
    send(2'd2);
    serve(ICMP, 0, 4'b0000, 1, "R7");
    serve(L2, 0, 4'b0000, 1, "R8");
    wait_done(L2, 4'b1011, "R8");
  endtask

  task automatic t_timeout;
    int el;
    build(48'h0200_0000_0008, 16'h0800, 8'd64, 8'd6, 32'h01020304, 32'h05060708, 1);
    send(2'd1);
    wait_done(L2, 4'b1101, "R9");
    el = cyc - grant_cyc;
    check(el < 320 && el > 200, "R9", "grant-to-done cycles", el, 320);
  endtask

  task automatic t_inflight;
    build(48'h0200_0000_0009, 16'h0800, 8'd9, 8'd6, 32'h01020304, 32'h05060709, 1);
    send(2'd0);
    fwd_disable = 1'b1;
    serve(L3, 1, 4'b1000, 1, "R2");
    wait_done(L3, 4'b1000, "R2");
    repeat (5) @(negedge clk);
    check(!pkt_req, "R2", "no request after disable", pkt_req, 0);
    fwd_disable = 1'b0;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_disable();
    t_rip_reset();
    t_l3();
    t_icmp();
    t_ethertype();
    t_l3_fail();
    t_fallback();
    t_timeout();
    t_inflight();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual expired expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule